// File: doc/BRIEF.md
# Capture Input Qualifier and Prescaler

This block conditions a raw, asynchronous capture input before it reaches the edge detector of a capture sequencer. The input first passes through a synchronizer chain. A glitch filter then suppresses short pulses. Its rejection window is set by a 4-bit qualification code, and a code of zero bypasses the filter. Last, an optional even-ratio divider reduces the event rate. It is set by a 5-bit prescale code, and a code of zero passes the filtered level straight through.

A one-cycle clear strobe puts the filter and the divider back to their initial state. Software uses it to restart capture cleanly after spurious activity that arrived while the block was being configured. Edge polarity selection and timestamping belong to the downstream sequencer and are not part of this block.

Top module: `cap_in_cond`

## Requirements
- R1: With both codes at 0, `cond_out` equals `raw_in` delayed by exactly two rising clock edges (two-flop synchronizer).
- R2: A qualification code of 0 bypasses the filter, so a one-cycle `raw_in` pulse appears at `cond_out`.
- R3: With a qualification code N in 1..15, a high or low pulse lasting N cycles or fewer leaves `cond_out` unchanged.
- R4: With a qualification code N in 1..15, a new level held for N+1 or more cycles is accepted. With prescale 0, `cond_out` takes the new level on the (N+3)th rising edge after `raw_in` changes.
- R5: A prescale code of 0 passes the filtered level to `cond_out` unchanged, so every accepted pulse appears as one pulse.
- R6: A prescale code N in 1..31 starts the output low and toggles it on every Nth rising edge of the filtered level. This divides the event rate by 2N, up to 62 at code 31.
- R7: A high `filt_clr` for one cycle clears the filter's run count and sets its level low. It also clears the divider's edge count, output and edge history. A level must then be held a full N+1 cycles again, and N new rising edges are needed before the next toggle.
- R8: While `rst` is high, and on the first cycle after it is released, `cond_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | 1 | Raw asynchronous capture input |
| qual_code | input | 4 | Glitch filter window; 0 bypasses the filter |
| pre_code | input | 5 | Divider code; 0 bypasses, N divides by 2N |
| filt_clr | input | 1 | One-cycle strobe that clears filter and divider state |
| cond_out | output | 1 | Conditioned, optionally divided level to the sequencer |

## Verification
The hardest case to reach is a clear strobe that lands while state is half-built. One example is a filter run count that has started but not finished. Another is a divider that has seen some, but not all, of its N edges. In either case only the timing of the next output change shows whether the state was really cleared. The stimulus holds `raw_in` high for only part of the qualification window and then strobes the clear. It expects the rising output a full N+1 cycles after the strobe rather than at its original time. For the divider, it feeds one edge under code 2, clears, and then requires two further edges before the toggle. A glitch-train case for the filter's low side holds the level high and inserts dips exactly N cycles long, which must not appear at the output.

// File: rtl/cap_cond_pkg.sv
package cap_cond_pkg;
    parameter int unsigned QUAL_W      = 4;
    parameter int unsigned PRE_W       = 5;
    parameter int unsigned SYNC_STAGES = 2;

    typedef logic [QUAL_W-1:0] qual_t;
    typedef logic [PRE_W-1:0]  pre_t;

    // Glitch filter state: accepted level and run length of the opposite level
    typedef struct packed {
        logic  lvl;
        qual_t run;
    } filt_st_t;

    // Divider state: previous input level, divided output, rising-edge count
    typedef struct packed {
        logic prev;
        logic div;
        pre_t edges;
    } pre_st_t;

    function automatic logic qual_bypass(qual_t c);
        return c == '0;
    endfunction

    function automatic logic pre_bypass(pre_t c);
        return c == '0;
    endfunction

    function automatic logic pre_last_edge(pre_t cnt, pre_t code);
        return cnt >= pre_t'(code - 1'b1);
    endfunction
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/cap_glitch_filt.sv
module cap_glitch_filt
    import cap_cond_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  d,
    input  qual_t qual,
    output logic  q
);
    filt_st_t st, st_nx;

    always_comb begin
        st_nx = st;
        if (clr) begin
            st_nx = '0;
        end else if (qual_bypass(qual)) begin
            st_nx.lvl = d;
            st_nx.run = '0;
        end else if (d == st.lvl) begin
            st_nx.run = '0;
        end else if (st.run >= qual) begin
            st_nx.lvl = d;
            st_nx.run = '0;
        end else begin
            st_nx.run = st.run + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_nx;
    end

    assign q = qual_bypass(qual) ? d : st.lvl;
endmodule

// File: rtl/cap_prescale.sv
module cap_prescale
    import cap_cond_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic d,
    input  pre_t pre,
    output logic q
);
    pre_st_t st, st_nx;

    always_comb begin
        st_nx = st;
        if (clr) begin
            st_nx = '0;
        end else begin
            st_nx.prev = d;
            if (pre_bypass(pre)) begin
                st_nx.div   = 1'b0;
                st_nx.edges = '0;
            end else if (d && !st.prev) begin
                if (pre_last_edge(st.edges, pre)) begin
                    st_nx.div   = !st.div;
                    st_nx.edges = '0;
                end else begin
                    st_nx.edges = st.edges + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_nx;
    end

    assign q = pre_bypass(pre) ? d : st.div;
endmodule

// File: rtl/cap_in_cond.sv
module cap_in_cond
    import cap_cond_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              raw_in,
    input  logic [QUAL_W-1:0] qual_code,
    input  logic [PRE_W-1:0]  pre_code,
    input  logic              filt_clr,
    output logic              cond_out
);
    logic sync_lvl;
    logic filt_lvl;

    cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_lvl)
    );

    cap_glitch_filt u_filt (
        .clk  (clk),
        .rst  (rst),
        .clr  (filt_clr),
        .d    (sync_lvl),
        .qual (qual_code),
        .q    (filt_lvl)
    );

    cap_prescale u_pre (
        .clk (clk),
        .rst (rst),
        .clr (filt_clr),
        .d   (filt_lvl),
        .pre (pre_code),
        .q   (cond_out)
    );
endmodule

// File: rtl/cap_in_cond_chk.sv
module cap_in_cond_chk
    import cap_cond_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              raw_in,
    input logic [QUAL_W-1:0] qual_code,
    input logic [PRE_W-1:0]  pre_code,
    input logic              filt_clr,
    input logic              cond_out,
    input logic              s2_lvl,
    input logic              filt_lvl
);
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 2'd3) age <= age + 1'b1;
    end

    // R1
    bypass_lag_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && qual_code == '0 && pre_code == '0) |-> cond_out == $past(raw_in, 2));

    // R4
    filt_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (qual_code != '0 && $stable(qual_code) && !$past(filt_clr) && filt_lvl != $past(filt_lvl))
        |-> filt_lvl == $past(s2_lvl));

    // R6
    div_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (pre_code != '0 && $stable(pre_code) && !$past(filt_clr) && cond_out != $past(cond_out))
        |-> $past(filt_lvl));

    // R7
    clr_div_chk: assert property (@(posedge clk) disable iff (rst)
        (filt_clr && pre_code != '0) |=> (pre_code == '0 || !cond_out));

    // R7
    clr_filt_chk: assert property (@(posedge clk) disable iff (rst)
        (filt_clr && qual_code != '0) |=> (qual_code == '0 || !filt_lvl));
endmodule

bind cap_in_cond cap_in_cond_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .raw_in    (raw_in),
    .qual_code (qual_code),
    .pre_code  (pre_code),
    .filt_clr  (filt_clr),
    .cond_out  (cond_out),
    .s2_lvl    (sync_lvl),
    .filt_lvl  (filt_lvl)
);

// File: tb/cap_in_cond_tb.sv
`timescale 1ns/1ps
module cap_in_cond_tb;
    import cap_cond_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              raw_in = 1'b0;
    logic [QUAL_W-1:0] qual_code = '0;
    logic [PRE_W-1:0]  pre_code = '0;
    logic              filt_clr = 1'b0;
    logic              cond_out;

    always #2 clk = ~clk;

    cap_in_cond u_dut (
        .clk       (clk),
        .rst       (rst),
        .raw_in    (raw_in),
        .qual_code (qual_code),
        .pre_code  (pre_code),
        .filt_clr  (filt_clr),
        .cond_out  (cond_out)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    exp_q[$];
    string tag_q[$];
    string cur_tag = "R8";
    logic  last_seen = 1'b0;
    bit    done = 1'b0;

    // bench model of the requirements
    int m_q = 0;
    int m_p = 0;
    bit m_lvl = 1'b0;
    int m_edges = 0;

    task automatic check(bit ok, string tag, int act, int exp, string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(bit v, string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic model_rise(string t);
        if (m_p == 0) push(1'b1, t);
        else begin
            m_edges++;
            if (m_edges == m_p) begin
                m_lvl = !m_lvl;
                push(m_lvl, t);
                m_edges = 0;
            end
        end
    endtask

    task automatic model_fall(string t);
        if (m_p == 0) push(1'b0, t);
    endtask

    task automatic pulse(int hi, int lo, string t);
        int lo_eff;
        lo_eff = (lo > m_q + 4) ? lo : m_q + 4;
        if (hi > m_q) begin
            model_rise(t);
            model_fall(t);
        end
        raw_in = 1'b1;
        tick(hi);
        raw_in = 1'b0;
        tick(lo_eff);
    endtask

    task automatic set_cfg(int q, int p, string t);
        raw_in = 1'b0;
        tick(30);
        check(exp_q.size() == 0, cur_tag, exp_q.size(), 0, "pending expected transitions");
        exp_q.delete();
        tag_q.delete();
        if (m_p != 0 && m_lvl) push(1'b0, "R7");
        filt_clr = 1'b1;
        tick(1);
        filt_clr = 1'b0;
        qual_code = QUAL_W'(q);
        pre_code  = PRE_W'(p);
        m_q = q; m_p = p; m_lvl = 1'b0; m_edges = 0;
        cur_tag = t;
        tick(5);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst) last_seen = 1'b0;
        else if (cond_out !== last_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_tag, int'(cond_out), int'(last_seen), "unexpected output transition");
            end else begin
                bit    e;
                string tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                check(cond_out === e, tg, int'(cond_out), int'(e), "output transition level");
            end
            last_seen = cond_out;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog run did not complete actual=1 expected=0");
        finish_run();
    end

    initial begin
        // R8 reset state
        raw_in = 1'b1;
        tick(4);
        check(cond_out == 1'b0, "R8", int'(cond_out), 0, "output during reset");
        raw_in = 1'b0;
        tick(2);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check(cond_out == 1'b0, "R8", int'(cond_out), 0, "output after reset release");

        // R1 synchronizer latency with both bypasses
        set_cfg(0, 0, "R1");
        push(1'b1, "R1");
        raw_in = 1'b1;
        @(posedge clk); @(negedge clk);
        check(cond_out == 1'b0, "R1", int'(cond_out), 0, "after one edge");
        @(posedge clk); @(negedge clk);
        check(cond_out == 1'b1, "R1", int'(cond_out), 1, "after two edges");
        push(1'b0, "R1");
        raw_in = 1'b0;
        tick(6);

        // R2 single-cycle pulse passes with filter bypass
        cur_tag = "R2";
        pulse(1, 6, "R2");
        pulse(2, 6, "R2");

        // R5 prescaler bypass passes every accepted pulse
        set_cfg(2, 0, "R5");
        for (int i = 0; i < 4; i++) pulse(3 + i, 6, "R5");

        // R3 / R4 filter window at code 3
        set_cfg(3, 0, "R3");
        pulse(1, 8, "R3");
        pulse(3, 8, "R3");
        pulse(4, 8, "R4");
        // R3 low dips of exactly N cycles while high
        push(1'b1, "R3");
        raw_in = 1'b1; tick(12);
        raw_in = 1'b0; tick(3);
        raw_in = 1'b1; tick(12);
        raw_in = 1'b0; tick(2);
        raw_in = 1'b1; tick(12);
        check(cond_out == 1'b1, "R3", int'(cond_out), 1, "level kept through short dips");
        push(1'b0, "R3");
        raw_in = 1'b0; tick(12);

        // R4 exact acceptance latency, N=3: change on edge N+3
        set_cfg(3, 0, "R4");
        push(1'b1, "R4");
        raw_in = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(cond_out == 1'b0, "R4", int'(cond_out), 0, "before edge N+3");
        @(posedge clk); @(negedge clk);
        check(cond_out == 1'b1, "R4", int'(cond_out), 1, "at edge N+3");
        push(1'b0, "R4");
        raw_in = 1'b0;
        tick(12);

        // R3 / R4 maximum window
        set_cfg(15, 0, "R3");
        pulse(15, 20, "R3");
        pulse(16, 20, "R4");

        // R7 clear restarts the filter run
        set_cfg(6, 0, "R7");
        raw_in = 1'b1;
        tick(5);
        filt_clr = 1'b1;
        push(1'b1, "R7");
        @(posedge clk); @(negedge clk);
        filt_clr = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check(cond_out == 1'b0, "R7", int'(cond_out), 0, "filter still counting after clear");
        @(posedge clk); @(negedge clk);
        check(cond_out == 1'b1, "R7", int'(cond_out), 1, "filter accepts after N+1 post-clear cycles");
        push(1'b0, "R7");
        raw_in = 1'b0;
        tick(12);

        // R6 divide by 2
        set_cfg(0, 1, "R6");
        for (int i = 0; i < 6; i++) pulse(3, 4, "R6");

        // R6 divide by 6 with filter and rejected glitches in between
        set_cfg(2, 3, "R6");
        for (int i = 0; i < 12; i++) begin
            pulse(4, 6, "R6");
            pulse(2, 6, "R6");
        end

        // R6 maximum ratio 62
        set_cfg(0, 31, "R6");
        for (int i = 0; i < 31; i++) pulse(3, 4, "R6");
        check(cond_out == 1'b1, "R6", int'(cond_out), 1, "toggle after 31 edges");
        for (int i = 0; i < 31; i++) pulse(3, 4, "R6");
        check(cond_out == 1'b0, "R6", int'(cond_out), 0, "full period after 62 edges");

        // R7 clear resets divider edge count
        set_cfg(0, 2, "R7");
        pulse(3, 4, "R7");
        filt_clr = 1'b1;
        tick(1);
        filt_clr = 1'b0;
        m_edges = 0;
        tick(3);
        pulse(3, 4, "R7");
        check(cond_out == 1'b0, "R7", int'(cond_out), 0, "no toggle one edge after clear");
        pulse(3, 4, "R7");
        check(cond_out == 1'b1, "R7", int'(cond_out), 1, "toggle after N post-clear edges");

        set_cfg(0, 0, "R5");
        finish_run();
    end
endmodule